// File: doc/BRIEF.md
# Constant-Weight Dot-Product Adder Tree

This block computes one output of a convolution as a single dot product. All input activations arrive side by side on one wide bus, and the block accepts a new vector on every clock. The filter weights are not a run-time input. They are fixed when the block is elaborated, through a packed parameter. Each lane that has a non-zero weight gets its own constant multiplier, and no multiplier is shared over time.

Each multiplier is specialised to its weight:
- A zero weight removes its lane entirely.
- A weight whose magnitude is a power of two becomes a shift, negated when the weight is negative.
- Any other weight becomes a multiplication by a constant.

The surviving products feed a binary adder tree with one register stage per level. A level with an odd number of operands carries the leftover operand through a register, so all paths stay aligned. A valid flag follows the data through a shift register of the same depth.

In a feature-map pipeline, one instance sits behind the window-forming logic for each output channel. Its weights are that channel's filter coefficients.

Top module: `dpt_dot_tree`

## Requirements
- R1: With in_valid high, lane i is `in_data[i*DATA_W +: DATA_W]` and its weight is `WEIGHTS[i*COEF_W +: COEF_W]`, both signed two's complement. The block outputs the exact signed sum over all lanes of lane times weight.
- R2: A vector presented before clock edge t gives its result on out_sum after edge t+LAT-1, where LAT = 1 + ceil(log2(P)) and P is the number of non-zero weights. Back-to-back vectors produce back-to-back results.
- R3: Lanes whose weight is a positive power of two (1, 16 in the default set) give exact products for the extreme inputs -128 and 127.
- R4: Lanes whose weight is a negative power of two (-1, -4, -128 in the default set) give exact products, including the most negative coefficient.
- R5: Lanes with a zero weight (lanes 1 and 4 in the default set) have no effect on out_sum, whatever value they carry.
- R6: out_sum is DATA_W + COEF_W + ceil(log2(P)) bits wide, signed. Vectors of all-maximum and all-minimum inputs give exact results with no wrap.
- R7: out_valid is in_valid delayed by exactly LAT cycles. It is low in every cycle that matches an input cycle with in_valid low.
- R8: A synchronous active-high rst clears out_valid and out_sum to zero on the next edge. It discards every vector still in flight.
- R9: The tree uses P-1 two-input adders, one register per level. An unpaired operand at a level passes unchanged through a register, so a product that is alone at its level stays aligned with its vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector qualifier |
| in_data | input | N_IN*DATA_W | Activations, lane i at bits i*DATA_W upward, signed |
| out_valid | output | 1 | Result qualifier, LAT cycles after in_valid |
| out_sum | output | DATA_W+COEF_W+ceil(log2(P)) | Signed dot product |

## Verification
The hardest case to expose from the ports is a misaligned pass-through register for the operand that is unpaired at its level. With seven surviving products, the last one is paired with nothing at the first level. A wrong delay on that path only shows when that lane changes between consecutive vectors while the other lanes keep contributing. The stimulus therefore includes a back-to-back burst in which lane 8 takes a new value every cycle. This is followed by long random bursts, gapped valid patterns, and a reset that lands while vectors are still in flight.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

    // Upper bound on the packed weight vector handed to the helper functions.
    localparam int WFLAT_MAX = 4096;

    typedef enum logic [1:0] {
        MK_SHIFT_POS,
        MK_SHIFT_NEG,
        MK_GENERIC
    } mult_kind_e;

    function automatic int abs_i(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic bit is_pow2(int v);
        int a;
        a = abs_i(v);
        return (a != 0) && ((a & (a - 1)) == 0);
    endfunction

    function automatic int flog2(int v);
        int r;
        r = 0;
        for (int a = abs_i(v); a > 1; a = a >> 1) r++;
        return r;
    endfunction

    function automatic int clog2_i(int n);
        int r;
        r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    // Operand count at tree level lvl when p operands enter level 0.
    function automatic int level_width(int p, int lvl);
        return (p + (1 << lvl) - 1) >> lvl;
    endfunction

    function automatic mult_kind_e kind_of(int w);
        if (is_pow2(w)) return (w < 0) ? MK_SHIFT_NEG : MK_SHIFT_POS;
        return MK_GENERIC;
    endfunction

    // Sign-extended weight of lane i from a packed coefficient vector.
    function automatic int weight_at(logic [WFLAT_MAX-1:0] flat, int cw, int i);
        int v;
        v = 0;
        for (int b = 0; b < 32; b++)
            v[b] = (b < cw) ? flat[i*cw + b] : flat[i*cw + cw - 1];
        return v;
    endfunction

    function automatic int count_nonzero(logic [WFLAT_MAX-1:0] flat, int n, int cw);
        int c;
        c = 0;
        for (int i = 0; i < n; i++)
            if (weight_at(flat, cw, i) != 0) c++;
        return c;
    endfunction

    // Lane index of the k-th non-zero weight.
    function automatic int nz_lane(logic [WFLAT_MAX-1:0] flat, int n, int cw, int k);
        int c;
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (weight_at(flat, cw, i) != 0) begin
                if (c == k) return i;
                c++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/dpt_const_mult.sv
module dpt_const_mult
    import dpt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PROD_W = 16,
    parameter int WEIGHT = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [PROD_W-1:0] p
);

    localparam mult_kind_e KIND = kind_of(WEIGHT);

    logic signed [PROD_W-1:0] x_ext;
    logic signed [PROD_W-1:0] p_d;

    assign x_ext = {{(PROD_W-DATA_W){x[DATA_W-1]}}, x};

    if (KIND == MK_SHIFT_POS) begin : g_shl
        localparam int SHIFT = flog2(WEIGHT);
        assign p_d = x_ext <<< SHIFT;
    end else if (KIND == MK_SHIFT_NEG) begin : g_shl_neg
        localparam int SHIFT = flog2(WEIGHT);
        assign p_d = -(x_ext <<< SHIFT);
    end else begin : g_mul
        localparam logic signed [PROD_W-1:0] COEF = PROD_W'(WEIGHT);
        assign p_d = x_ext * COEF;
    end

    always_ff @(posedge clk) begin
        if (rst) p <= '0;
        else     p <= p_d;
    end

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R3 (positive shift) and R4 (negated shift): registered product equals the integer product
    p_const_product_r3: assert property (@(posedge clk) disable iff (rst)
        armed |-> (int'(p) == int'($past(x)) * WEIGHT));

endmodule

// File: rtl/dpt_tree_level.sv
module dpt_tree_level #(
    parameter int N_L = 7,
    parameter int W   = 19
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_L*W-1:0]             d,
    output logic [((N_L+1)/2)*W-1:0]     q
);

    localparam int PAIRS = N_L / 2;

    logic [((N_L+1)/2)*W-1:0] q_d;

    for (genvar j = 0; j < PAIRS; j++) begin : g_add
        assign q_d[j*W +: W] = d[2*j*W +: W] + d[(2*j+1)*W +: W];
    end

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    if (N_L % 2 == 1) begin : g_pass
        assign q_d[PAIRS*W +: W] = d[(N_L-1)*W +: W];

        // R9: the unpaired operand reaches the next level one cycle later, unchanged
        p_odd_pass_r9: assert property (@(posedge clk) disable iff (rst)
            armed |-> (q[PAIRS*W +: W] == $past(d[(N_L-1)*W +: W])));
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_d;
    end

    logic [W-1:0] sum_in, sum_out;
    always_comb begin
        sum_in = '0;
        for (int i = 0; i < N_L; i++) sum_in = sum_in + d[i*W +: W];
        sum_out = '0;
        for (int i = 0; i < (N_L+1)/2; i++) sum_out = sum_out + q[i*W +: W];
    end

    // R9: a level neither loses nor invents value between its input and its register
    p_sum_kept_r9: assert property (@(posedge clk) disable iff (rst)
        armed |-> (sum_out == $past(sum_in)));

endmodule

// File: rtl/dpt_dot_tree.sv
module dpt_dot_tree
    import dpt_pkg::*;
#(
    parameter int N_IN   = 9,
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter logic [N_IN*COEF_W-1:0] WEIGHTS = 72'hFD_10_FF_80_00_01_FC_00_03,
    localparam int P      = count_nonzero(WFLAT_MAX'(WEIGHTS), N_IN, COEF_W),
    localparam int DEPTH  = clog2_i(P),
    localparam int PROD_W = DATA_W + COEF_W,
    localparam int OUT_W  = PROD_W + DEPTH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [N_IN*DATA_W-1:0]   in_data,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_sum
);

    localparam int LAT = 1 + DEPTH;
    localparam int CW  = clog2_i(LAT + 1) + 1;

    wire in_data_unused = ^in_data;

    // Valid pipeline matching the data latency
    logic [LAT-1:0] vld_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= in_valid;
            for (int i = 1; i < LAT; i++) vld_q[i] <= vld_q[i-1];
        end
    end
    assign out_valid = vld_q[LAT-1];

    if (P == 0) begin : g_empty
        assign out_sum = '0;
    end else begin : g_tree
        logic [P*OUT_W-1:0] leaf;

        for (genvar k = 0; k < P; k++) begin : g_leaf
            localparam int LANE = nz_lane(WFLAT_MAX'(WEIGHTS), N_IN, COEF_W, k);
            localparam int WGT  = weight_at(WFLAT_MAX'(WEIGHTS), COEF_W, LANE);
            logic signed [PROD_W-1:0] prod;

            dpt_const_mult #(
                .DATA_W (DATA_W),
                .PROD_W (PROD_W),
                .WEIGHT (WGT)
            ) u_mult (
                .clk (clk),
                .rst (rst),
                .x   (in_data[LANE*DATA_W +: DATA_W]),
                .p   (prod)
            );

            assign leaf[k*OUT_W +: OUT_W] = OUT_W'(prod);
        end

        for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
            localparam int NI = level_width(P, l);
            localparam int NO = level_width(P, l + 1);
            logic [NI*OUT_W-1:0] d;
            logic [NO*OUT_W-1:0] q;

            if (l == 0) begin : g_first
                assign d = leaf;
            end else begin : g_next
                assign d = g_lvl[l-1].q;
            end

            dpt_tree_level #(
                .N_L (NI),
                .W   (OUT_W)
            ) u_lvl (
                .clk (clk),
                .rst (rst),
                .d   (d),
                .q   (q)
            );
        end

        if (DEPTH == 0) begin : g_single
            assign out_sum = leaf;
        end else begin : g_root
            assign out_sum = g_lvl[DEPTH-1].q;
        end
    end

    // Cycles since reset, saturating at LAT, to bound the look-back below
    logic [CW-1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                         since_rst <= '0;
        else if (since_rst != CW'(LAT))  since_rst <= since_rst + CW'(1);
    end

    // R7: out_valid is in_valid delayed by LAT
    p_valid_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == CW'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    // R8: the edge after a reset leaves both outputs cleared
    p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_sum == '0));

endmodule

// File: tb/dpt_dot_tree_tb_top.sv
`timescale 1ns/1ps
module dpt_dot_tree_tb_top;

    localparam int N_IN   = 9;
    localparam int DATA_W = 8;
    localparam int COEF_W = 8;
    localparam int LAT    = 4;   // 1 multiplier stage + ceil(log2(7)) tree levels
    localparam int OUT_W  = 19;  // 8 + 8 + 3
    localparam logic [N_IN*COEF_W-1:0] WEIGHTS = 72'hFD_10_FF_80_00_01_FC_00_03;

    int coef [N_IN] = '{3, 0, -4, 1, 0, -128, -1, 16, -3};

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    in_valid = 1'b0;
    logic [N_IN*DATA_W-1:0]  in_data = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_sum;

    dpt_dot_tree #(
        .N_IN    (N_IN),
        .DATA_W  (DATA_W),
        .COEF_W  (COEF_W),
        .WEIGHTS (WEIGHTS)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    always #2.5 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int     sum;
        longint due;
        string  tag;
    } exp_t;
    exp_t sb[$];

    function automatic int model(logic [N_IN*DATA_W-1:0] v);
        int s;
        s = 0;
        for (int i = 0; i < N_IN; i++)
            s += int'($signed(v[i*DATA_W +: DATA_W])) * coef[i];
        return s;
    endfunction

    function automatic logic [N_IN*DATA_W-1:0] rand_vec();
        logic [N_IN*DATA_W-1:0] v;
        for (int i = 0; i < N_IN; i++) v[i*DATA_W +: DATA_W] = 8'($urandom);
        return v;
    endfunction

    function automatic logic [N_IN*DATA_W-1:0] one_lane(int lane, logic [7:0] val);
        logic [N_IN*DATA_W-1:0] v;
        v = '0;
        v[lane*DATA_W +: DATA_W] = val;
        return v;
    endfunction

    // Driver: acts just after the falling edge, pushes the expected item
    task automatic drive(input logic [N_IN*DATA_W-1:0] v, input logic vld, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        in_data  = v;
        in_valid = vld;
        if (vld) begin
            e.sum = model(v);
            e.due = cyc + LAT;
            e.tag = tag;
            sb.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, 1'b0, "");
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1;
        rst      = 1'b1;
        in_valid = 1'b0;
        sb.delete();
        repeat (2) @(negedge clk);
        // R8: outputs cleared while reset is held
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8 out_valid in reset: actual=%0b expected=0", out_valid);
        end
        checks++;
        if (out_sum !== '0) begin
            errors++;
            $display("FAIL R8 out_sum in reset: actual=%0d expected=0", out_sum);
        end
        #1;
        rst = 1'b0;
    endtask

    // Monitor: compares results as they appear
    exp_t   item;
    logic   due_now;
    always @(negedge clk) begin
        if (!rst) begin
            due_now = (sb.size() > 0) && (sb[0].due == cyc);
            checks++;
            if (out_valid !== due_now) begin
                errors++;
                $display("FAIL R7 out_valid at cycle %0d: actual=%0b expected=%0b",
                         cyc, out_valid, due_now);
            end
            if (due_now) begin
                item = sb.pop_front();
                checks++;
                if (out_sum !== OUT_W'(item.sum)) begin
                    errors++;
                    $display("FAIL %s out_sum at cycle %0d: actual=%0d expected=%0d",
                             item.tag, cyc, out_sum, item.sum);
                end
            end
        end
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog (R2 pipeline stalled): actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N_IN*DATA_W-1:0] v;
        repeat (3) @(posedge clk);
        // R8: reset state
        do_reset();

        // R1/R2: single vector, then a gap in which out_valid must stay low (R7)
        drive(72'h0102030405060708_09, 1'b1, "R1 single");
        idle(6);

        // R3: positive power-of-two lanes (weight 1 at lane 3, weight 16 at lane 7)
        drive(one_lane(3, 8'h7F) | one_lane(7, 8'h80), 1'b1, "R3 shl -128");
        drive(one_lane(7, 8'h7F), 1'b1, "R3 shl 127");
        drive(one_lane(3, 8'h80), 1'b1, "R3 unit -128");

        // R4: negative power-of-two lanes (-4 at lane 2, -128 at lane 5, -1 at lane 6)
        drive(one_lane(5, 8'h80), 1'b1, "R4 neg -128*-128");
        drive(one_lane(5, 8'h7F), 1'b1, "R4 neg -128*127");
        drive(one_lane(2, 8'h80), 1'b1, "R4 neg -4");
        drive(one_lane(6, 8'h80), 1'b1, "R4 neg -1");

        // R6: extremes back to back
        drive({N_IN{8'h7F}}, 1'b1, "R6 all max");
        drive({N_IN{8'h80}}, 1'b1, "R6 all min");
        drive({N_IN{8'h80}} & ~one_lane(5, 8'hFF), 1'b1, "R6 min without lane5");
        idle(2);

        // R5: zero-weight lanes 1 and 4 carry different junk, result unchanged
        v = rand_vec();
        drive(v & ~(one_lane(1, 8'hFF) | one_lane(4, 8'hFF)), 1'b1, "R5 lanes clear");
        drive(v | one_lane(1, 8'hFF) | one_lane(4, 8'hFF), 1'b1, "R5 lanes set");
        drive((v & ~(one_lane(1, 8'hFF) | one_lane(4, 8'hFF)))
              | one_lane(1, 8'h80) | one_lane(4, 8'h7F), 1'b1, "R5 lanes mixed");
        idle(1);

        // R9: unpaired product (lane 8) changes every cycle, the rest held
        v = rand_vec();
        for (int i = 0; i < 16; i++) begin
            v[8*DATA_W +: DATA_W] = 8'(i * 37 + 5);
            drive(v, 1'b1, "R9 odd lane");
        end

        // R1/R2: long random back-to-back burst
        for (int i = 0; i < 40; i++) drive(rand_vec(), 1'b1, "R1 burst");

        // R7: gapped valid pattern with random data in the gaps
        for (int i = 0; i < 24; i++) drive(rand_vec(), (i % 3) != 0, "R7 gapped");
        idle(LAT + 2);

        // R8: reset while vectors are in flight; none may emerge afterwards
        drive(rand_vec(), 1'b1, "R8 flushed");
        drive(rand_vec(), 1'b1, "R8 flushed");
        drive(rand_vec(), 1'b1, "R8 flushed");
        do_reset();
        idle(LAT + 3);
        drive(rand_vec(), 1'b1, "R8 after reset");
        idle(LAT + 3);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 results outstanding: actual=%0d expected=0", sb.size());
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule